// File: doc/BRIEF.md
# Streaming Sobel Edge Detector

This block turns a raster-order stream of packed RGB pixels into a stream of 8-bit edge strengths. It takes one pixel per clock, and a pixel counts only when the producer raises `in_valid` while the block shows `in_ready`. Each accepted pixel is reduced to an approximate 8-bit luma value by shifts and adds. The luma value then enters a flat shift buffer that is two image rows plus three entries long. Nine taps of that buffer form a 3x3 window. The horizontal and vertical Sobel kernels are applied to the window, the absolute values of the two responses are summed, and the sum is clamped to 8 bits.

The controller has two states. In `ST_PRIME`, which is entered at reset, the block shifts zeros into the buffer for exactly 2*IMG_COLS+3 cycles and keeps `in_ready` low. The `PRIME_DONE` transition then moves it to `ST_RUN`. In `ST_RUN` every accepted pixel produces exactly one output, one cycle later. A cycle with `in_valid` low freezes the buffer and produces no output. The only transition back to `ST_PRIME` is reset. The image width is a parameter. Border pixels are not cropped: their windows simply include the zeros from priming or pixels from the neighbouring row.

Top module: `sobel_stream_edge`

## Requirements
- R1: Luma is (2*R + B + 3*G) >> 3, taking R from input bits 7:0, G from bits 15:8 and B from bits 23:16, truncated to 8 bits.
- R2: The buffer holds 2*IMG_COLS+3 luma entries. The newest accepted pixel is at index 0, and each shift moves entry i to index i+1. The window tap for kernel row r and column c (each 0..2) is buffer index r*IMG_COLS+c, read after the shift for the current pixel.
- R3: Gx uses the kernel rows {-1,-2,-1}, {0,0,0}, {1,2,1}. Gy uses the kernel rows {-1,0,1}, {-2,0,2}, {-1,0,1}. Row and column are indexed as in R2.
- R4: Gx and Gy are held in 12-bit signed registers and never wrap. Their magnitude never exceeds 1020. The output is |Gx| + |Gy| whenever that sum is at most 255.
- R5: When |Gx| + |Gy| exceeds 255, the output is 255.
- R6: After reset the block stays in `ST_PRIME` for exactly 2*IMG_COLS+3 cycles, with `in_ready` and `out_valid` both low. During this time zeros are shifted into the buffer. `in_ready` then goes high and stays high until the next reset.
- R7: `out_valid` is high in the cycle after each accepted pixel, and only then. `out_mag` holds that pixel's result in that cycle.
- R8: A cycle with `in_valid` low shifts nothing and produces no output on the next cycle. Results for later pixels are the same as if the idle cycle had not occurred.
- R9: Reset clears the buffer and the priming counter. Pixels accepted before a reset have no effect on any result after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_pixel | input | 24 | Packed pixel: B in 23:16, G in 15:8, R in 7:0 |
| in_ready | output | 1 | High once priming has finished |
| out_valid | output | 1 | Edge magnitude present |
| out_mag | output | 8 | Clamped L1 edge magnitude |

## Verification
Two things can land in the same cycle. One is the output of a pixel accepted on the previous edge. The other is a stall, with `in_valid` low in the current cycle. The bench provokes this by inserting random idle gaps between pixels. In that cycle it requires the pending result to appear unchanged. On the following cycle it requires no output. It also requires that every later window is computed as if the gap had never existed. A second overlap occurs when a clamped result meets a stall. The bench drives high-contrast columns so that these two coincide.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
    localparam int ACC_W = 12;
    typedef logic [7:0] luma_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef enum logic {ST_PRIME = 1'b0, ST_RUN = 1'b1} sobel_state_e;

    // horizontal-gradient coefficient for window row r, column c
    function automatic int coef_x(input int r, input int c);
        return (r - 1) * ((c == 1) ? 2 : 1);
    endfunction

    // vertical-gradient coefficient for window row r, column c
    function automatic int coef_y(input int r, input int c);
        return (c - 1) * ((r == 1) ? 2 : 1);
    endfunction
endpackage

// File: rtl/sobel_luma.sv
module sobel_luma
    import sobel_pkg::*;
(
    input  logic [23:0] pix,
    output luma_t       y
);
    logic [10:0] weighted;

    always_comb begin
        weighted = {2'b00, pix[7:0], 1'b0}
                 + {3'b000, pix[23:16]}
                 + {3'b000, pix[15:8]}
                 + {2'b00, pix[15:8], 1'b0};
        y = weighted[10:3];
    end
endmodule

// File: rtl/sobel_window_buf.sv
module sobel_window_buf
    import sobel_pkg::*;
#(
    parameter int IMG_COLS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        shift_en,
    input  luma_t       din,
    output logic [71:0] taps_flat
);
    localparam int BUF_LEN = 2 * IMG_COLS + 3;

    luma_t line_q [BUF_LEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_LEN; i++) line_q[i] <= '0;
        end else if (shift_en) begin
            line_q[0] <= din;
            for (int i = 1; i < BUF_LEN; i++) line_q[i] <= line_q[i-1];
        end
    end

    // taps view the buffer as it stands after the current shift
    for (genvar r = 0; r < 3; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            localparam int IDX = r * IMG_COLS + c;
            if (IDX == 0) begin : g_new
                assign taps_flat[(r*3+c)*8 +: 8] = din;
            end else begin : g_old
                assign taps_flat[(r*3+c)*8 +: 8] = line_q[IDX-1];
            end
        end
    end

    // R8: a frozen cycle leaves the buffer untouched
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(line_q[0]) && $stable(line_q[BUF_LEN-1])));
endmodule

// File: rtl/sobel_kernel_acc.sv
module sobel_kernel_acc
    import sobel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_en,
    input  logic [71:0] taps_flat,
    output acc_t        gx,
    output acc_t        gy
);
    int   sum_x;
    int   sum_y;

    always_comb begin
        sum_x = 0;
        sum_y = 0;
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                sum_x += coef_x(r, c) * int'(taps_flat[(r*3+c)*8 +: 8]);
                sum_y += coef_y(r, c) * int'(taps_flat[(r*3+c)*8 +: 8]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gx <= '0;
            gy <= '0;
        end else if (load_en) begin
            gx <= acc_t'(sum_x);
            gy <= acc_t'(sum_y);
        end
    end

    // R4: gradients stay within the range a 3x3 window of 8-bit values allows
    assert_grad_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gx <= 12'sd1020) && (gx >= -12'sd1020) && (gy <= 12'sd1020) && (gy >= -12'sd1020));
endmodule

// File: rtl/sobel_mag_clamp.sv
module sobel_mag_clamp
    import sobel_pkg::*;
(
    input  acc_t        gx,
    input  acc_t        gy,
    output logic [7:0]  mag
);
    logic [ACC_W-1:0] abs_x;
    logic [ACC_W-1:0] abs_y;
    logic [ACC_W:0]   total;

    always_comb begin
        abs_x = gx[ACC_W-1] ? ACC_W'(-gx) : ACC_W'(gx);
        abs_y = gy[ACC_W-1] ? ACC_W'(-gy) : ACC_W'(gy);
        total = {1'b0, abs_x} + {1'b0, abs_y};
        mag   = (|total[ACC_W:8]) ? 8'hFF : total[7:0];
    end
endmodule

// File: rtl/sobel_stream_edge.sv
module sobel_stream_edge
    import sobel_pkg::*;
#(
    parameter int IMG_COLS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [23:0] in_pixel,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_mag
);
    localparam int PRIME_LEN = 2 * IMG_COLS + 3;
    localparam int CNT_W     = $clog2(PRIME_LEN + 1);

    sobel_state_e     state_q, state_d;
    logic [CNT_W-1:0] prime_cnt;
    logic             fire;
    logic             shift_en;
    luma_t            luma_y;
    luma_t            buf_din;
    logic [71:0]      taps_flat;
    acc_t             gx, gy;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (prime_cnt == CNT_W'(PRIME_LEN - 1)) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // state register and priming counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_PRIME;
            prime_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PRIME) prime_cnt <= prime_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        shift_en = 1'b0;
        buf_din  = '0;
        unique case (state_q)
            ST_PRIME: begin
                shift_en = 1'b1;
            end
            ST_RUN: begin
                in_ready = 1'b1;
                shift_en = in_valid;
                buf_din  = luma_y;
            end
        endcase
    end

    assign fire = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= fire;
    end

    sobel_luma u_luma (
        .pix (in_pixel),
        .y   (luma_y)
    );

    sobel_window_buf #(.IMG_COLS(IMG_COLS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .din       (buf_din),
        .taps_flat (taps_flat)
    );

    sobel_kernel_acc u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (fire),
        .taps_flat (taps_flat),
        .gx        (gx),
        .gy        (gy)
    );

    sobel_mag_clamp u_mag (
        .gx  (gx),
        .gy  (gy),
        .mag (out_mag)
    );

    // R6: priming ends only after the full count
    assert_prime_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> ($past(prime_cnt) == CNT_W'(PRIME_LEN - 1)));
    // R6: no result leaves while priming
    assert_no_out_prime_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |-> !out_valid);
    // R7: every output follows a cycle with valid input
    assert_out_follows_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R8: an idle input cycle yields no output next
    assert_idle_no_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4: zero gradients give a zero magnitude
    assert_zero_grad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && gx == '0 && gy == '0) |-> (out_mag == 8'd0));
endmodule

// File: tb/test_sobel_stream_edge.sv
module test_sobel_stream_edge;
    localparam int COLS    = 8;
    localparam int BUF_LEN = 2 * COLS + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_pixel = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_mag;

    int n_checks = 0;
    int n_fail   = 0;
    int hist [BUF_LEN];
    int clamp_seen = 0;

    always #2 clk = ~clk;

    sobel_stream_edge #(.IMG_COLS(COLS)) i_sobel_stream_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pixel  (in_pixel),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_mag   (out_mag)
    );

    function automatic int ref_luma(input logic [23:0] p);
        return ((2 * int'(p[7:0])) + int'(p[23:16]) + (3 * int'(p[15:8]))) >> 3;
    endfunction

    function automatic int ref_mag();
        int kxr[3][3] = '{'{-1,-2,-1}, '{0,0,0}, '{1,2,1}};
        int kyr[3][3] = '{'{-1,0,1}, '{-2,0,2}, '{-1,0,1}};
        int sx = 0;
        int sy = 0;
        int m;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                sx += kxr[r][c] * hist[r*COLS+c];
                sy += kyr[r][c] * hist[r*COLS+c];
            end
        m = (sx < 0 ? -sx : sx) + (sy < 0 ? -sy : sy);
        return (m > 255) ? 255 : m;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < BUF_LEN; i++) hist[i] = 0;
    endtask

    // called at a negedge; drives one cycle, checks the result at the next negedge
    task automatic step(input logic v, input logic [23:0] p, input string tag);
        int exp_m;
        in_valid = v;
        in_pixel = p;
        exp_m = 0;
        if (v) begin
            for (int i = BUF_LEN - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = ref_luma(p);
            exp_m = ref_mag();
            if (exp_m == 255) clamp_seen++;
        end
        @(negedge clk);
        check({tag, " out_valid"}, int'(out_valid), int'(v));
        if (v) check({tag, " out_mag"}, int'(out_mag), exp_m);
    endtask

    task automatic do_reset_and_prime(input string tag);
        in_valid = 1'b0;
        rst_n = 1'b0;
        clear_hist();
        @(negedge clk);
        @(negedge clk);
        check({tag, " reset in_ready"}, int'(in_ready), 0);
        check({tag, " reset out_valid"}, int'(out_valid), 0);
        rst_n = 1'b1;
        // pixels offered during priming must not be taken
        in_valid = 1'b1;
        in_pixel = 24'hFFFFFF;
        for (int i = 0; i < BUF_LEN - 1; i++) @(negedge clk);
        check({tag, " in_ready low one cycle before prime end"}, int'(in_ready), 0);
        check({tag, " no output during prime"}, int'(out_valid), 0);
        in_valid = 1'b0;
        @(negedge clk);
        check({tag, " in_ready after prime"}, int'(in_ready), 1);
        check({tag, " out_valid after prime"}, int'(out_valid), 0);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        logic [23:0] pxv;
        seed = 32'd12345;
        void'($urandom(seed));
        @(negedge clk);
        do_reset_and_prime("R6 R9");

        // R1: single colour lanes at full scale
        step(1'b1, 24'h0000FF, "R1 red lane");
        step(1'b1, 24'h00FF00, "R1 green lane");
        step(1'b1, 24'hFF0000, "R1 blue lane");
        step(1'b1, 24'h102030, "R1 mixed");

        // R2 R3 R4: random stream with full pipeline
        for (int i = 0; i < 60; i++) step(1'b1, 24'($urandom()), "R2 R3 R4 random");

        // R5: high-contrast columns to drive the clamp
        for (int i = 0; i < 4 * COLS; i++)
            step(1'b1, ((i % 2) == 0) ? 24'hFFFFFF : 24'h000000, "R5 clamp");

        // R7 R8: random gaps, stall meeting pending output
        for (int i = 0; i < 300; i++) begin
            pxv = ($urandom() % 3 == 0) ? 24'hFFFFFF : 24'($urandom());
            step(($urandom() % 3) != 0, pxv, "R7 R8 gaps");
        end
        step(1'b0, 24'hABCDEF, "R8 idle");
        step(1'b0, 24'h123456, "R8 idle");
        step(1'b1, 24'h00FF00, "R8 resume");

        // R5: confirm saturation was exercised
        check("R5 clamp reached", int'(clamp_seen > 0), 1);

        // R9: reset mid-stream clears history
        do_reset_and_prime("R9 second reset");
        step(1'b1, 24'h000000, "R9 first after reset");
        step(1'b1, 24'hFFFFFF, "R9 second after reset");
        for (int i = 0; i < 40; i++) step(1'b1, 24'($urandom()), "R9 R2 after reset");

        in_valid = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule